// File: doc/BRIEF.md
# JTAG Targeted Scan Shifter

This block runs one instruction-register or data-register scan aimed at a single device in a daisy-chained JTAG path. It keeps its own copy of the TAP controller state and walks that state machine to the shift state of the selected register. It then clocks out three runs of bits in order: bypass padding for the devices ahead of the target, the payload, and bypass padding for the devices behind it. After that it walks to the matching update state.

Each system clock in which `tck_en_o` is high stands for one TCK period. In that cycle `tms_o` and `tdi_o` are the values presented to the chain, and `tdo_i` is the chain's answer for the same bit. Payload bits arrive on `din_i` when the block asks for them with `din_req_o`. Captured bits leave on `cap_bit_o` while `cap_valid_o` is high. After a data scan the block can add a number of Run-Test/Idle clocks that the caller chooses.

Top module: `jtag_scan_shifter`

## Requirements
- R1: After reset `busy_o`, `tck_en_o`, `done_o`, `err_o` and `cap_count_o` are all zero, and the tracked TAP state is Test-Logic-Reset.
- R2: The walk into the shift state takes the shortest TMS path. From Test-Logic-Reset it is 0,1,0,0 for a data scan and 0,1,1,0,0 for an instruction scan. From Run-Test/Idle or from either update state it is 1,0,0 for a data scan and 1,1,0,0 for an instruction scan.
- R3: The shift clocks come as `pre_i` padding bits, then `len_i` payload bits, then `post_i` padding bits. Padding drives `tdi_o` to 1 for an instruction scan (`is_ir_i`=1) and to 0 for a data scan.
- R4: Payload bits are taken from `din_i` least significant first. There is exactly one `din_req_o` clock per payload bit, and `tdi_o` equals `din_i` in those clocks.
- R5: TMS is 0 on every shift clock except the final one (the last post bit, or the last payload bit when `post_i` is 0), which carries TMS=1. One further TMS=1 clock then reaches the update state. TDI is 0 on every walk clock.
- R6: When `capture_i` is set, `cap_valid_o` is high on exactly the payload clocks and `cap_bit_o` equals `tdo_i`. It is never high on padding or walk clocks, and never high when `capture_i` is clear.
- R7: After a data-scan update with a nonzero `idle_i`, the block issues `idle_i`+1 further clocks with TMS and TDI at 0: one to enter Run-Test/Idle, then `idle_i` idle clocks. An instruction scan ignores `idle_i`.
- R8: A start with `len_i`=0 is rejected. `err_o` pulses one cycle later, no TCK clock is issued and `busy_o` stays low.
- R9: `done_o` pulses for one cycle after the last clock of a scan. `cap_count_o` then holds `len_i` if capture was enabled, and 0 otherwise.
- R10: `busy_o` is high from the cycle after an accepted start until the last clock. A `start_i` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, one TCK period per enabled cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan with the request fields below |
| is_ir_i | input | 1 | 1 selects an instruction scan, 0 a data scan |
| len_i | input | LEN_W | Payload bit count |
| pre_i | input | PAD_W | Padding bits before the payload |
| post_i | input | PAD_W | Padding bits after the payload |
| idle_i | input | IDLE_W | Extra idle clocks after a data scan |
| capture_i | input | 1 | Enable payload capture from TDO |
| din_i | input | 1 | Current payload bit |
| din_req_o | output | 1 | Payload bit consumed this cycle |
| tck_en_o | output | 1 | Issue one TCK clock this cycle |
| tms_o | output | 1 | TMS for this clock |
| tdi_o | output | 1 | TDI for this clock |
| tdo_i | input | 1 | TDO answer for this clock |
| cap_valid_o | output | 1 | `cap_bit_o` holds a captured payload bit |
| cap_bit_o | output | 1 | Captured TDO bit |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at scan end |
| err_o | output | 1 | One-cycle pulse on a rejected zero-length start |
| cap_count_o | output | LEN_W | Captured bit count of the last scan |

## Verification
The bench builds the block with LEN_W=7, PAD_W=3 and IDLE_W=3. These widths make the widest padding (7 bits each side) and the longest idle run (7 clocks) cheap enough to exercise next to one-bit payloads and a zero-length reject. Scans start from each of the three resting TAP states that the block can leave behind: reset, idle and update. This reaches every hard-coded walk path. One scan carries a stray start pulse mid-flight to show that requests are not accepted while busy.

// File: rtl/jtag_scan_pkg.sv
package jtag_scan_pkg;

  typedef enum logic [3:0] {
    T_RESET, T_IDLE,
    T_SEL_DR, T_CAP_DR, T_SHF_DR, T_EX1_DR, T_PAU_DR, T_EX2_DR, T_UPD_DR,
    T_SEL_IR, T_CAP_IR, T_SHF_IR, T_EX1_IR, T_PAU_IR, T_EX2_IR, T_UPD_IR
  } tap_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WALK_IN, PH_PRE, PH_PAY, PH_POST, PH_WALK_OUT, PH_RUN
  } phase_e;

  function automatic tap_e tap_next(tap_e s, logic tms);
    unique case (s)
      T_RESET:  return tms ? T_RESET  : T_IDLE;
      T_IDLE:   return tms ? T_SEL_DR : T_IDLE;
      T_SEL_DR: return tms ? T_SEL_IR : T_CAP_DR;
      T_CAP_DR: return tms ? T_EX1_DR : T_SHF_DR;
      T_SHF_DR: return tms ? T_EX1_DR : T_SHF_DR;
      T_EX1_DR: return tms ? T_UPD_DR : T_PAU_DR;
      T_PAU_DR: return tms ? T_EX2_DR : T_PAU_DR;
      T_EX2_DR: return tms ? T_UPD_DR : T_SHF_DR;
      T_UPD_DR: return tms ? T_SEL_DR : T_IDLE;
      T_SEL_IR: return tms ? T_RESET  : T_CAP_IR;
      T_CAP_IR: return tms ? T_EX1_IR : T_SHF_IR;
      T_SHF_IR: return tms ? T_EX1_IR : T_SHF_IR;
      T_EX1_IR: return tms ? T_UPD_IR : T_PAU_IR;
      T_PAU_IR: return tms ? T_EX2_IR : T_PAU_IR;
      T_EX2_IR: return tms ? T_UPD_IR : T_SHF_IR;
      default:  return tms ? T_SEL_DR : T_IDLE;
    endcase
  endfunction

  function automatic logic is_ir_side(tap_e s);
    return s inside {T_SEL_IR, T_CAP_IR, T_SHF_IR, T_EX1_IR, T_PAU_IR, T_EX2_IR, T_UPD_IR};
  endfunction

  // TMS bit that moves one step closer to a shift or update target
  function automatic logic tap_step(tap_e s, tap_e tgt);
    unique case (s)
      T_RESET:            return 1'b0;
      T_SEL_DR:           return is_ir_side(tgt);
      T_SEL_IR:           return !is_ir_side(tgt);
      T_CAP_DR:           return tgt != T_SHF_DR;
      T_CAP_IR:           return tgt != T_SHF_IR;
      T_EX2_DR:           return tgt != T_SHF_DR;
      T_EX2_IR:           return tgt != T_SHF_IR;
      default:            return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/jtag_tap_track.sv
module jtag_tap_track
  import jtag_scan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tck_en_i,
  input  logic tms_i,
  output tap_e tap_o
);
  tap_e tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tap_q <= T_RESET;
    else if (tck_en_i) tap_q <= tap_next(tap_q, tms_i);
  end

  assign tap_o = tap_q;
endmodule

// File: rtl/jtag_scan_ctrl.sv
module jtag_scan_ctrl
  import jtag_scan_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int PAD_W  = 4,
  parameter int IDLE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_ir_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PAD_W-1:0]  pre_i,
  input  logic [PAD_W-1:0]  post_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic              capture_i,
  input  tap_e              tap_i,
  output phase_e            phase_o,
  output logic              is_ir_o,
  output logic              capture_o,
  output logic              tck_en_o,
  output logic              tms_o,
  output logic              done_o,
  output logic              err_o,
  output logic [LEN_W-1:0]  cap_count_o
);
  localparam int MAX_W = (LEN_W > PAD_W) ? ((LEN_W > IDLE_W) ? LEN_W : IDLE_W)
                                         : ((PAD_W > IDLE_W) ? PAD_W : IDLE_W);
  localparam int CNT_W = MAX_W + 1;

  phase_e phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q;
  logic              is_ir_q, cap_q, clr, fin, done_q, err_q;
  logic [LEN_W-1:0]  len_q, cap_cnt_q;
  logic [PAD_W-1:0]  pre_q, post_q;
  logic [IDLE_W-1:0] idle_q;
  logic              accept;
  tap_e              shf_tgt, upd_tgt;
  logic [CNT_W-1:0]  cnt_inc;

  assign accept  = (phase_q == PH_IDLE) && start_i && (len_i != '0);
  assign shf_tgt = is_ir_q ? T_SHF_IR : T_SHF_DR;
  assign upd_tgt = is_ir_q ? T_UPD_IR : T_UPD_DR;
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    phase_d  = phase_q;
    tck_en_o = 1'b0;
    tms_o    = 1'b0;
    clr      = 1'b0;
    fin      = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        clr = 1'b1;
        if (accept) phase_d = PH_WALK_IN;
      end
      PH_WALK_IN: begin
        if (tap_i == shf_tgt) begin
          clr     = 1'b1;
          phase_d = (pre_q != '0) ? PH_PRE : PH_PAY;
        end else begin
          tck_en_o = 1'b1;
          tms_o    = tap_step(tap_i, shf_tgt);
        end
      end
      PH_PRE: begin
        tck_en_o = 1'b1;
        if (cnt_inc == CNT_W'(pre_q)) begin
          clr     = 1'b1;
          phase_d = PH_PAY;
        end
      end
      PH_PAY: begin
        tck_en_o = 1'b1;
        if (cnt_inc == CNT_W'(len_q)) begin
          clr     = 1'b1;
          tms_o   = (post_q == '0);
          phase_d = (post_q != '0) ? PH_POST : PH_WALK_OUT;
        end
      end
      PH_POST: begin
        tck_en_o = 1'b1;
        if (cnt_inc == CNT_W'(post_q)) begin
          clr     = 1'b1;
          tms_o   = 1'b1;
          phase_d = PH_WALK_OUT;
        end
      end
      PH_WALK_OUT: begin
        if (tap_i == upd_tgt) begin
          clr = 1'b1;
          if (!is_ir_q && idle_q != '0) phase_d = PH_RUN;
          else begin
            phase_d = PH_IDLE;
            fin     = 1'b1;
          end
        end else begin
          tck_en_o = 1'b1;
          tms_o    = tap_step(tap_i, upd_tgt);
        end
      end
      PH_RUN: begin
        // one clock into idle, then idle_q more
        tck_en_o = 1'b1;
        if (cnt_q == CNT_W'(idle_q)) begin
          phase_d = PH_IDLE;
          fin     = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      is_ir_q   <= 1'b0;
      cap_q     <= 1'b0;
      len_q     <= '0;
      pre_q     <= '0;
      post_q    <= '0;
      idle_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      cap_cnt_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (clr)           cnt_q <= '0;
      else if (tck_en_o) cnt_q <= cnt_inc;
      if (accept) begin
        is_ir_q <= is_ir_i;
        cap_q   <= capture_i;
        len_q   <= len_i;
        pre_q   <= pre_i;
        post_q  <= post_i;
        idle_q  <= idle_i;
      end
      done_q <= fin;
      err_q  <= (phase_q == PH_IDLE) && start_i && (len_i == '0);
      if (fin) cap_cnt_q <= cap_q ? len_q : '0;
    end
  end

  assign phase_o     = phase_q;
  assign is_ir_o     = is_ir_q;
  assign capture_o   = cap_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign cap_count_o = cap_cnt_q;
endmodule

// File: rtl/jtag_scan_data.sv
module jtag_scan_data
  import jtag_scan_pkg::*;
(
  input  phase_e phase_i,
  input  logic   is_ir_i,
  input  logic   capture_i,
  input  logic   din_i,
  input  logic   tdo_i,
  output logic   din_req_o,
  output logic   tdi_o,
  output logic   cap_valid_o,
  output logic   cap_bit_o
);
  always_comb begin
    unique case (phase_i)
      PH_PRE, PH_POST: tdi_o = is_ir_i;  // bypass fill
      PH_PAY:          tdi_o = din_i;
      default:         tdi_o = 1'b0;
    endcase
  end

  assign din_req_o   = (phase_i == PH_PAY);
  assign cap_valid_o = (phase_i == PH_PAY) && capture_i;
  assign cap_bit_o   = tdo_i;
endmodule

// File: rtl/jtag_scan_shifter.sv
module jtag_scan_shifter
  import jtag_scan_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int PAD_W  = 4,
  parameter int IDLE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_ir_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PAD_W-1:0]  pre_i,
  input  logic [PAD_W-1:0]  post_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic              capture_i,
  input  logic              din_i,
  output logic              din_req_o,
  output logic              tck_en_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i,
  output logic              cap_valid_o,
  output logic              cap_bit_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [LEN_W-1:0]  cap_count_o
);
  tap_e   tap;
  phase_e phase;
  logic   is_ir, cap_en;

  jtag_tap_track u_tap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tck_en_i (tck_en_o),
    .tms_i    (tms_o),
    .tap_o    (tap)
  );

  jtag_scan_ctrl #(
    .LEN_W  (LEN_W),
    .PAD_W  (PAD_W),
    .IDLE_W (IDLE_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .is_ir_i     (is_ir_i),
    .len_i       (len_i),
    .pre_i       (pre_i),
    .post_i      (post_i),
    .idle_i      (idle_i),
    .capture_i   (capture_i),
    .tap_i       (tap),
    .phase_o     (phase),
    .is_ir_o     (is_ir),
    .capture_o   (cap_en),
    .tck_en_o    (tck_en_o),
    .tms_o       (tms_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .cap_count_o (cap_count_o)
  );

  jtag_scan_data u_data (
    .phase_i     (phase),
    .is_ir_i     (is_ir),
    .capture_i   (cap_en),
    .din_i       (din_i),
    .tdo_i       (tdo_i),
    .din_req_o   (din_req_o),
    .tdi_o       (tdi_o),
    .cap_valid_o (cap_valid_o),
    .cap_bit_o   (cap_bit_o)
  );

  assign busy_o = (phase != PH_IDLE);
endmodule

// File: rtl/jtag_scan_shifter_chk.sv
module jtag_scan_shifter_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             din_i,
  input logic             din_req_o,
  input logic             tck_en_o,
  input logic             tms_o,
  input logic             tdi_o,
  input logic             cap_valid_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [LEN_W-1:0] cap_count_o
);
  // R10
  tck_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_en_o |-> busy_o);

  // R6
  cap_in_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_o |-> (tck_en_o && din_req_o));

  // R4
  pay_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_req_o |-> (tck_en_o && tdi_o == din_i && !tms_o || tck_en_o && tdi_o == din_i));

  // R8
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !tck_en_o));

  // R9
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !busy_o) |=> $stable(cap_count_o) || done_o);
endmodule

bind jtag_scan_shifter jtag_scan_shifter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .din_i       (din_i),
  .din_req_o   (din_req_o),
  .tck_en_o    (tck_en_o),
  .tms_o       (tms_o),
  .tdi_o       (tdi_o),
  .cap_valid_o (cap_valid_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .cap_count_o (cap_count_o)
);

// File: tb/jtag_scan_shifter_tb.sv
module jtag_scan_shifter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 7, PAD_W = 3, IDLE_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, is_ir = 1'b0, capture = 1'b0, din = 1'b0, tdo = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic [PAD_W-1:0] pre = '0, post = '0;
  logic [IDLE_W-1:0] idle = '0;
  logic din_req, tck_en, tms, tdi, cap_valid, cap_bit, busy, done, err;
  logic [LEN_W-1:0] cap_count;

  int checks = 0, errors = 0;
  int where_at = 0;  // 0 reset, 1 idle, 2 update
  logic [15:0] lfsr = 16'hACE1;
  int q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_scan_shifter #(.LEN_W(LEN_W), .PAD_W(PAD_W), .IDLE_W(IDLE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .is_ir_i(is_ir), .len_i(len),
    .pre_i(pre), .post_i(post), .idle_i(idle), .capture_i(capture), .din_i(din),
    .din_req_o(din_req), .tck_en_o(tck_en), .tms_o(tms), .tdi_o(tdi), .tdo_i(tdo),
    .cap_valid_o(cap_valid), .cap_bit_o(cap_bit), .busy_o(busy), .done_o(done),
    .err_o(err), .cap_count_o(cap_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // bit0 tms, bit1 tdi, bit2 capture expected
  function automatic void push(int t, int d, int c);
    q.push_back(t | (d << 1) | (c << 2));
  endfunction

  task automatic run_scan(input bit ir, input int n, input int npre, input int npost,
                          input int nidle, input bit cp, input logic [127:0] pay,
                          input bit poke);
    int pidx = 0;
    int cyc = 0;
    bit busy_ok = 1'b1;
    q.delete();
    // R2 walk-in paths
    if (where_at == 0) begin
      push(0,0,0); push(1,0,0);
      if (ir) push(1,0,0);
      push(0,0,0); push(0,0,0);
    end else begin
      push(1,0,0);
      if (ir) push(1,0,0);
      push(0,0,0); push(0,0,0);
    end
    // R3 R5 shift body
    for (int i = 0; i < npre; i++) push(0, ir, 0);
    for (int i = 0; i < n; i++) push((i == n-1 && npost == 0), pay[i], cp);
    for (int i = 0; i < npost; i++) push(i == npost-1, ir, 0);
    push(1,0,0);
    // R7 idle tail for data scans only
    if (!ir && nidle > 0) for (int i = 0; i <= nidle; i++) push(0,0,0);
    where_at = (!ir && nidle > 0) ? 1 : 2;

    @(negedge clk);
    is_ir = ir; len = LEN_W'(n); pre = PAD_W'(npre); post = PAD_W'(npost);
    idle = IDLE_W'(nidle); capture = cp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      din = pay[pidx];
      tdo = lfsr[0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (poke && cyc == 3) begin start = 1'b1; len = '0; end
      else start = 1'b0;
      #1;
      if (done) break;
      if (!busy) busy_ok = 1'b0;
      if (err) check(1'b0, "R10 start while busy ignored", err, 0);
      if (tck_en) begin
        if (q.size() == 0) check(1'b0, "R5 extra clock", 1, 0);
        else begin
          int e = q.pop_front();
          check(tms == e[0], "R2/R5 tms", tms, e[0]);
          check(tdi == e[1], "R3/R4 tdi", tdi, e[1]);
          check(cap_valid == e[2], "R6 capture window", cap_valid, e[2]);
          if (e[2]) check(cap_bit == tdo, "R6 captured bit", cap_bit, tdo);
          if (din_req) pidx++;
        end
      end else if (din_req || cap_valid) check(1'b0, "R4 req without clock", 1, 0);
      cyc++;
      if (cyc > 2000) begin check(1'b0, "scan hung", cyc, 0); break; end
      @(negedge clk);
    end
    start = 1'b0;
    check(q.size() == 0, "R5 clocks missing", q.size(), 0);
    check(busy_ok, "R10 busy through scan", busy_ok, 1);
    check(pidx == n, "R4 payload requests", pidx, n);
    check(cap_count == (cp ? n : 0), "R9 capture count", cap_count, cp ? n : 0);
    check(!busy, "R10 busy low at done", busy, 0);
    @(negedge clk); #1;
    check(!done, "R9 done single pulse", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk); #1;
    // R1
    check(!busy && !tck_en && !done && !err, "R1 reset outputs", busy, 0);
    check(cap_count == 0, "R1 reset count", cap_count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_scan(0, 8, 0, 0, 0, 1, 128'hA5, 0);              // R2 from reset, data
    run_scan(1, 4, 7, 7, 5, 0, 128'h9, 0);               // R3 R7 max pad, idle ignored
    run_scan(0, 13, 2, 1, 3, 1, 128'h1B3C, 0);           // R7 idle tail
    run_scan(1, 5, 0, 4, 0, 1, 128'h16, 0);              // R2 from idle, IR
    run_scan(0, 1, 1, 0, 1, 1, 128'h1, 0);               // R5 single payload bit
    run_scan(0, 6, 3, 2, 0, 1, 128'h2D, 1);              // R10 stray start
    run_scan(1, 70, 1, 1, 0, 1, {64'h0, 64'hF0E1D2C3B4A59687}, 0); // R4 long payload

    // R8 zero length rejected
    @(negedge clk);
    len = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; #1;
    check(err == 1'b1, "R8 error pulse", err, 1);
    check(!busy && !tck_en, "R8 no clocks", tck_en, 0);
    @(negedge clk); #1;
    check(!err && !busy && !tck_en, "R8 stays quiet", busy, 0);

    // R2 path from update after rejected start still intact
    run_scan(0, 3, 0, 2, 0, 0, 128'h5, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule